// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block handles one cache miss at a time. It sits between the data array of a cache and a memory port that returns one word per beat. It fetches a whole multi-word line and releases the waiting processor as soon as the missed word arrives, without waiting for the rest of the line. A mode input chooses between two burst orders. In wrapping order the burst starts at the missed word and wraps around the line. In linear order the burst starts at word 0 of the line and counts upward, and the processor is still released on the beat that carries its word.

Every beat the memory port accepts is written into the line buffer at the offset it belongs to, whatever order the words come in. Forwarding and writes advance only on accepted beats, so the memory side can stall the request and the beats through valid/ready handshakes. The line tag and its valid flag are committed only after the last word has been stored. While a refill is in flight the block holds `busy` high and ignores any new miss. The line buffer can be read one word at a time through a read port on the array side.

Top module: `lineRefill`

## Requirements
- R1: After reset, `busy`, `lineValid`, `memReqValid`, `memBeatReady`, `lineWe` and `respValid` are all 0.
- R2: A miss presented while `busy` is 0 is accepted on that clock edge. From the next cycle, `busy` is 1 and `memReqValid` is 1, and `busy` stays 1 until the line is committed.
- R3: With `modeCwf` = 1 at acceptance, the burst request carries the full missed word address and `memReqWrap` = 1. The k-th accepted beat (k counted from 0) is written at line offset (missed offset + k) mod WORDS.
- R4: With `modeCwf` = 0 at acceptance, the burst request carries the line base address (offset bits zero) and `memReqWrap` = 0. The k-th accepted beat is written at offset k.
- R5: In the cycle a beat is accepted (`memBeatValid` and `memBeatReady` both 1), `lineWe` is 1 and `lineWdata` equals the beat data. After the refill, `rdData` for every offset `rdIdx` returns the word written there.
- R6: `respValid` is 1 in exactly one cycle per refill: the cycle in which the beat for the missed offset is accepted. In that cycle `respData` equals that beat's data.
- R7: `lineValid` drops to 0 when a miss is accepted and stays 0 through the last beat. It rises, with `lineTag` equal to the upper address bits above the offset, on the second clock edge after the last beat is accepted. `busy` falls on the same edge.
- R8: While `busy` is 1, `missValid` has no effect: no second burst request is issued, and the committed tag is that of the miss that was accepted.
- R9: `memReqValid` and `memReqAddr` hold steady until `memReqReady` is seen. A cycle with `memBeatValid` = 0 writes nothing, forwards nothing and does not advance the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| missValid | input | 1 | Miss request from the processor |
| missAddr | input | ADDR_W | Missed word address |
| modeCwf | input | 1 | 1 = wrapping critical-word-first burst, 0 = linear burst from word 0 |
| busy | output | 1 | Refill in progress; new misses are ignored |
| respValid | output | 1 | Missed word forwarded this cycle |
| respData | output | DATA_W | Forwarded word |
| memReqValid | output | 1 | Burst request valid |
| memReqReady | input | 1 | Memory accepts the burst request |
| memReqAddr | output | ADDR_W | Starting word address of the burst |
| memReqWrap | output | 1 | Burst wraps at the line boundary |
| memBeatValid | input | 1 | Memory presents a data beat |
| memBeatReady | output | 1 | Block accepts beats |
| memBeatData | input | DATA_W | Beat data |
| lineWe | output | 1 | Line buffer write strobe |
| lineWordIdx | output | log2(WORDS) | Offset being written |
| lineWdata | output | DATA_W | Word being written |
| lineValid | output | 1 | Line content and tag are valid |
| lineTag | output | ADDR_W-log2(WORDS) | Committed line tag |
| rdIdx | input | log2(WORDS) | Line buffer read offset |
| rdData | output | DATA_W | Line buffer read data |

## Verification
The case that is hardest to reach from the ports is a wrapping burst whose missed word sits late in the line. There the release falls in the middle of the burst, while stall cycles shift the point where the offset wraps to zero and a competing miss is being held on the processor side. The stimulus gets there by giving every refill its own missed offset and mode, inserting pseudo-random stall cycles on both the request and the beat handshakes, and keeping `missValid` high with a different address for most of one refill. A beat-by-beat model then predicts the offset, the write data and whether the word is forwarded for each accepted beat.

// File: rtl/refillPkg.sv
package refillPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_BEAT   = 2'd2,
    ST_FINISH = 2'd3
  } refillState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureMiss;  // latch address and mode, drop line valid
    logic startBurst;   // request accepted, clear beat counter
    logic beatFire;     // one beat accepted this cycle
    logic commitLine;   // write tag, raise line valid
  } refillStrobes_t;

endpackage

// File: rtl/refillCtrl.sv
module refillCtrl
  import refillPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           missValid,
  input  logic           memReqReady,
  input  logic           memBeatValid,
  input  logic           lastBeat,
  output logic           busy,
  output logic           memReqValid,
  output logic           memBeatReady,
  output refillStrobes_t strb
);

  refillState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (missValid)                 stateD = ST_REQ;
      ST_REQ:    if (memReqReady)               stateD = ST_BEAT;
      ST_BEAT:   if (memBeatValid && lastBeat)  stateD = ST_FINISH;
      ST_FINISH:                                stateD = ST_IDLE;
      default:                                  stateD = ST_IDLE;
    endcase
  end

  assign busy         = (stateQ != ST_IDLE);
  assign memReqValid  = (stateQ == ST_REQ);
  assign memBeatReady = (stateQ == ST_BEAT);

  always_comb begin
    strb             = '0;
    strb.captureMiss = (stateQ == ST_IDLE)   && missValid;
    strb.startBurst  = (stateQ == ST_REQ)    && memReqReady;
    strb.beatFire    = (stateQ == ST_BEAT)   && memBeatValid;
    strb.commitLine  = (stateQ == ST_FINISH);
  end

endmodule

// File: rtl/refillDatapath.sv
module refillDatapath
  import refillPkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  refillStrobes_t              strb,
  input  logic [ADDR_W-1:0]           missAddr,
  input  logic                        modeCwf,
  input  logic [DATA_W-1:0]           memBeatData,
  input  logic [$clog2(WORDS)-1:0]    rdIdx,
  output logic                        lastBeat,
  output logic [ADDR_W-1:0]           memReqAddr,
  output logic                        memReqWrap,
  output logic                        respValid,
  output logic [DATA_W-1:0]           respData,
  output logic                        lineWe,
  output logic [$clog2(WORDS)-1:0]    lineWordIdx,
  output logic [DATA_W-1:0]           lineWdata,
  output logic                        lineValid,
  output logic [ADDR_W-$clog2(WORDS)-1:0] lineTag,
  output logic [DATA_W-1:0]           rdData
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] reqAddrQ;
  logic              cwfQ;
  logic [OFF_W-1:0]  beatCntQ;
  logic [OFF_W-1:0]  critIdx;
  logic [OFF_W-1:0]  startIdx;
  logic [OFF_W-1:0]  curIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] lineWords [WORDS];

  assign critIdx  = reqAddrQ[OFF_W-1:0];
  assign reqTag   = reqAddrQ[ADDR_W-1:OFF_W];
  assign startIdx = cwfQ ? critIdx : '0;
  // power-of-two line length: the adder wraps at the line boundary
  assign curIdx   = startIdx + beatCntQ;
  assign lastBeat = (beatCntQ == OFF_W'(WORDS - 1));

  // miss capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ <= '0;
      cwfQ     <= 1'b0;
    end else if (strb.captureMiss) begin
      reqAddrQ <= missAddr;
      cwfQ     <= modeCwf;
    end
  end

  // beat counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                beatCntQ <= '0;
    else if (strb.startBurst) beatCntQ <= '0;
    else if (strb.beatFire)   beatCntQ <= beatCntQ + 1'b1;
  end

  // burst request fields
  assign memReqAddr = cwfQ ? reqAddr : {reqTag, {OFF_W{1'b0}}};
  assign memReqWrap = cwfQ;

  // processor release and array write port
  assign respValid   = strb.beatFire && (curIdx == critIdx);
  assign respData    = memBeatData;
  assign lineWe      = strb.beatFire;
  assign lineWordIdx = curIdx;
  assign lineWdata   = memBeatData;

  // line buffer storage, one register per word
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= '0;
      else if (strb.beatFire && (curIdx == OFF_W'(w)))
        wordQ <= memBeatData;
    end
    assign lineWords[w] = wordQ;
  end

  assign rdData = lineWords[rdIdx];

  // tag and valid
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineValid <= 1'b0;
      lineTag   <= '0;
    end else if (strb.captureMiss) begin
      lineValid <= 1'b0;
    end else if (strb.commitLine) begin
      lineValid <= 1'b1;
      lineTag   <= reqTag;
    end
  end

  logic [ADDR_W-1:0] reqAddr;
  assign reqAddr = reqAddrQ;

endmodule

// File: rtl/lineRefill.sv
module lineRefill
  import refillPkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            missValid,
  input  logic [ADDR_W-1:0]               missAddr,
  input  logic                            modeCwf,
  output logic                            busy,
  output logic                            respValid,
  output logic [DATA_W-1:0]               respData,
  output logic                            memReqValid,
  input  logic                            memReqReady,
  output logic [ADDR_W-1:0]               memReqAddr,
  output logic                            memReqWrap,
  input  logic                            memBeatValid,
  output logic                            memBeatReady,
  input  logic [DATA_W-1:0]               memBeatData,
  output logic                            lineWe,
  output logic [$clog2(WORDS)-1:0]        lineWordIdx,
  output logic [DATA_W-1:0]               lineWdata,
  output logic                            lineValid,
  output logic [ADDR_W-$clog2(WORDS)-1:0] lineTag,
  input  logic [$clog2(WORDS)-1:0]        rdIdx,
  output logic [DATA_W-1:0]               rdData
);

  refillStrobes_t strb;
  logic           lastBeat;

  refillCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .missValid    (missValid),
    .memReqReady  (memReqReady),
    .memBeatValid (memBeatValid),
    .lastBeat     (lastBeat),
    .busy         (busy),
    .memReqValid  (memReqValid),
    .memBeatReady (memBeatReady),
    .strb         (strb)
  );

  refillDatapath #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .missAddr    (missAddr),
    .modeCwf     (modeCwf),
    .memBeatData (memBeatData),
    .rdIdx       (rdIdx),
    .lastBeat    (lastBeat),
    .memReqAddr  (memReqAddr),
    .memReqWrap  (memReqWrap),
    .respValid   (respValid),
    .respData    (respData),
    .lineWe      (lineWe),
    .lineWordIdx (lineWordIdx),
    .lineWdata   (lineWdata),
    .lineValid   (lineValid),
    .lineTag     (lineTag),
    .rdData      (rdData)
  );

endmodule

// File: rtl/lineRefillChecker.sv
module lineRefillChecker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              busy,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memBeatReady,
  input logic              lineWe,
  input logic [DATA_W-1:0] lineWdata,
  input logic              respValid,
  input logic [DATA_W-1:0] respData,
  input logic              lineValid
);

  // tracks whether the processor was already released in this refill
  logic respSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          respSeen <= 1'b0;
    else if (!busy)     respSeen <= 1'b0;
    else if (respValid) respSeen <= 1'b1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && missValid) |=> (busy && memReqValid));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReqValid && !memBeatReady && !lineWe && !respValid));

  p_resp_is_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (lineWe && (lineWdata == respData)));

  p_single_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !respSeen);

  p_invalid_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !lineValid);

  p_no_second_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReqValid) |=> !memReqValid);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

endmodule

bind lineRefill lineRefillChecker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .missValid    (missValid),
  .busy         (busy),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqAddr   (memReqAddr),
  .memBeatReady (memBeatReady),
  .lineWe       (lineWe),
  .lineWdata    (lineWdata),
  .respValid    (respValid),
  .respData     (respData),
  .lineValid    (lineValid)
);

// File: tb/lineRefill_tb_top.sv
`timescale 1ns/1ps
module lineRefill_tb_top;

  localparam int WORDS  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 24;
  localparam int OFF_W  = $clog2(WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              missValid = 1'b0;
  logic [ADDR_W-1:0] missAddr = '0;
  logic              modeCwf = 1'b0;
  logic              busy, respValid, memReqValid, memReqWrap, memBeatReady;
  logic              lineWe, lineValid;
  logic [DATA_W-1:0] respData, lineWdata, rdData;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memReqReady = 1'b0;
  logic              memBeatValid = 1'b0;
  logic [DATA_W-1:0] memBeatData = '0;
  logic [OFF_W-1:0]  lineWordIdx;
  logic [OFF_W-1:0]  rdIdx = '0;
  logic [TAG_W-1:0]  lineTag;

  lineRefill #(.WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .modeCwf(modeCwf), .busy(busy), .respValid(respValid), .respData(respData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqWrap(memReqWrap), .memBeatValid(memBeatValid), .memBeatReady(memBeatReady),
    .memBeatData(memBeatData), .lineWe(lineWe), .lineWordIdx(lineWordIdx),
    .lineWdata(lineWdata), .lineValid(lineValid), .lineTag(lineTag),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] beatWord(input logic [ADDR_W-1:0] a, input int idx);
    return 32'(a[ADDR_W-1:OFF_W]) * 32'd40503 + 32'(idx) * 32'h01010101 + 32'hC0DE0000;
  endfunction

  int stallSeed = 7;
  function automatic bit stallNow(input int pct);
    stallSeed = (stallSeed * 1103515245 + 12345) & 32'h7fffffff;
    return ((stallSeed >> 8) % 100) < pct;
  endfunction

  // one full refill with a beat-by-beat model of the expected outputs
  task automatic runMiss(input logic [ADDR_W-1:0] addr, input bit cwf,
                         input int stallPct, input bit intrude);
    int order[$];
    int crit = int'(addr[OFF_W-1:0]);
    int respCount = 0;
    logic [ADDR_W-1:0] expReq = cwf ? addr : {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    logic [DATA_W-1:0] stored [WORDS];
    bit rdy;
    bit v;

    for (int k = 0; k < WORDS; k++) order.push_back(cwf ? (crit + k) % WORDS : k);

    @(negedge clk);
    missValid = 1'b1; missAddr = addr; modeCwf = cwf;
    #1 chk("R2", "busy before accept", 64'(busy), 64'd0);

    @(negedge clk);
    missValid = intrude; missAddr = addr ^ 24'h000100; modeCwf = ~cwf;
    #1;
    chk("R2", "busy after accept", 64'(busy), 64'd1);
    chk("R7", "lineValid dropped", 64'(lineValid), 64'd0);

    // request phase, with stalls
    forever begin
      rdy = !stallNow(stallPct);
      memReqReady = rdy;
      #1;
      chk("R9", "memReqValid held", 64'(memReqValid), 64'd1);
      chk(cwf ? "R3" : "R4", "memReqAddr", 64'(memReqAddr), 64'(expReq));
      chk(cwf ? "R3" : "R4", "memReqWrap", 64'(memReqWrap), 64'(cwf));
      @(negedge clk);
      if (rdy) break;
    end
    memReqReady = 1'b0;

    // beat phase
    while (order.size() > 0) begin
      v = !stallNow(stallPct);
      memBeatValid = v;
      memBeatData = v ? beatWord(addr, order[0]) : 32'hDEAD0000;
      if (order.size() == 1) missValid = 1'b0;
      #1;
      chk("R8", "no second request", 64'(memReqValid), 64'd0);
      chk("R5", "lineWe", 64'(lineWe), 64'(v));
      chk("R7", "lineValid during fill", 64'(lineValid), 64'd0);
      if (v) begin
        chk(cwf ? "R3" : "R4", "lineWordIdx", 64'(lineWordIdx), 64'(order[0]));
        chk("R5", "lineWdata", 64'(lineWdata), 64'(beatWord(addr, order[0])));
        chk("R6", "respValid on beat", 64'(respValid), 64'(order[0] == crit));
        if (order[0] == crit) begin
          chk("R6", "respData", 64'(respData), 64'(beatWord(addr, crit)));
          respCount++;
        end
        stored[order[0]] = beatWord(addr, order[0]);
      end else begin
        chk("R9", "respValid on stall", 64'(respValid), 64'd0);
      end
      @(negedge clk);
      if (v) void'(order.pop_front());
    end
    memBeatValid = 1'b0;
    chk("R6", "release count", 64'(respCount), 64'd1);

    // commit cycle
    #1;
    chk("R7", "busy in commit cycle", 64'(busy), 64'd1);
    chk("R7", "lineValid in commit cycle", 64'(lineValid), 64'd0);
    @(negedge clk);
    #1;
    chk("R7", "busy after commit", 64'(busy), 64'd0);
    chk("R7", "lineValid after commit", 64'(lineValid), 64'd1);
    chk(intrude ? "R8" : "R7", "lineTag", 64'(lineTag), 64'(addr[ADDR_W-1:OFF_W]));
    for (int i = 0; i < WORDS; i++) begin
      rdIdx = OFF_W'(i);
      #0.2 chk("R5", "rdData", 64'(rdData), 64'(stored[i]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy in reset", 64'(busy), 64'd0);
    chk("R1", "lineValid in reset", 64'(lineValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "busy", 64'(busy), 64'd0);
    chk("R1", "lineValid", 64'(lineValid), 64'd0);
    chk("R1", "memReqValid", 64'(memReqValid), 64'd0);
    chk("R1", "memBeatReady", 64'(memBeatReady), 64'd0);
    chk("R1", "lineWe", 64'(lineWe), 64'd0);
    chk("R1", "respValid", 64'(respValid), 64'd0);

    runMiss(24'h012342, 1'b1, 0, 1'b0);   // R3 wrap from offset 2, no stalls
    runMiss(24'h0ABCD3, 1'b1, 40, 1'b0);  // R3 wrap from last offset, stalls
    runMiss(24'h055552, 1'b0, 40, 1'b0);  // R4 linear, release mid-burst
    runMiss(24'h077770, 1'b0, 0, 1'b0);   // R4 linear, release on first beat
    runMiss(24'h033330, 1'b1, 30, 1'b0);  // R3 wrap from offset 0
    runMiss(24'h0F00D1, 1'b1, 50, 1'b1);  // R8 competing miss held high
    runMiss(24'h0E0E03, 1'b0, 50, 1'b1);  // R8 linear, release on last beat
    for (int n = 0; n < 20; n++)
      runMiss(ADDR_W'(n * 24'h01357B + 24'h000200), n[0], 35, n[1]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule